// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Sticky Interrupt Capture

This block is a general-purpose I/O peripheral for up to 32 pins, reached over a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software controls each pin through several per-pin registers:

- an output enable, an output data bit and an output inversion bit;
- a pull-up enable and an input enable;
- a drive-strength setting, which is only stored.

Two alternate-function registers are also only stored. An external-drive port models off-chip drivers. It has a per-pin "driven" mask and a per-pin value.

On every clock the block works out each pin's level. It then samples that level through the input enable into a read-only value register. From the sampled value it captures four classes of sticky pending bits: level-high, level-low, rising edge and falling edge. Each class has its own enable register. The enabled pending bits are ORed into one interrupt line per pin. Software clears pending bits by writing ones. A contention output flags every pin that is driven both by the block and externally.

Top module: `gpio_pin_irq`

Register byte offsets are: value 0x00, input enable 0x04, output enable 0x08, output data 0x0C, output invert 0x10, pull-up 0x14, drive strength 0x18, alternate-function enable 0x1C, alternate-function select 0x20, high enable 0x24, high pending 0x28, low enable 0x2C, low pending 0x30, rise enable 0x34, rise pending 0x38, fall enable 0x3C, fall pending 0x40. Bit n of every register belongs to pin n.

## Requirements
- R1: With no external drive, a pin whose output enable is 1 shows output data XOR output invert on `pin_level`, in the same cycle the registers hold those values.
- R2: The level of a pin is chosen by fixed priority:
  - if its `ext_drive` bit is 1, the level is its `ext_val` bit;
  - otherwise, if the output is enabled, the level is the internal output level;
  - otherwise, the level is the pull-up bit.
- R3: The value register at 0x00 captures input enable AND pin level one clock after the level appears. Writes to 0x00 have no effect.
- R4: A high pending bit sets on every cycle the sampled value of its pin is 1. A low pending bit sets on every cycle the sampled value is 0. Both stay set until cleared.
- R5: A rise pending bit sets when the newly sampled value is 1 and the stored value is 0. A fall pending bit sets on the opposite transition. Both are sticky.
- R6: Writing a pending register clears the bits written as 1 and keeps the bits written as 0. When a clear and a set fall in the same cycle, the bit ends up set.
- R7: `irq[n]` is 1 exactly when some pending class of pin n has both its pending bit and its enable bit at 1.
- R8: Reset sets every register, the stored value and all pending bits to zero, and `irq` reads zero.
- R9: Every mapped control register, including drive strength and the alternate-function registers, reads back what was written. A read of an unmapped offset returns zero, and a write to one changes no register.
- R10: `contention[n]` is 1 exactly when `ext_drive[n]` and the output enable of pin n are both 1. In that case the external value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ext_drive | input | 32 | Per-pin mask of pins driven off-chip |
| ext_val | input | 32 | Off-chip drive value per pin |
| pin_level | output | 32 | Resolved level of each pin |
| contention | output | 32 | Pin driven both internally and externally |
| irq | output | 32 | Per-pin interrupt |

## Verification
The stimulus table walks pins through each branch of the level priority, including inversion, pull-up fallback and external override while the output is enabled. A design with the priority reversed would show the internal level where the external one belongs, and a wrong contention term would flag the wrong pins.

Directed tests clear a low pending bit while its condition still holds, and expect it to read back set. A design where the clear wins would leave it at zero. They also write partial masks to a pending register, where a design that assigned instead of clearing would drop bits. Writes to the value register and to an unmapped offset must leave every register untouched.

Edge pending bits must set only on a real transition of the stored value. A design that compared against the wrong cycle would miss the edge or report it twice.

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   ext_drive,
  input  logic [NPIN-1:0]   ext_val,
  output logic [NPIN-1:0]   pin_level,
  output logic [NPIN-1:0]   contention,
  output logic [NPIN-1:0]   irq
);
  localparam logic [ADDR_W-1:0] A_VAL  = 'h00, A_IEN  = 'h04, A_OEN  = 'h08,
                                A_ODAT = 'h0C, A_OINV = 'h10, A_PULL = 'h14,
                                A_DRV  = 'h18, A_AFEN = 'h1C, A_AFSL = 'h20,
                                A_HIE  = 'h24, A_HIP  = 'h28, A_LIE  = 'h2C,
                                A_LIP  = 'h30, A_RIE  = 'h34, A_RIP  = 'h38,
                                A_FIE  = 'h3C, A_FIP  = 'h40;

  logic [NPIN-1:0] ien, oen, odat, oinv, pull, drv, afen, afsl;
  logic [NPIN-1:0] hie, lie, rie, fie, hip, lip, rip, fip, val_q;
  logic [NPIN-1:0] drive_int, samp;

  assign drive_int  = oen & (odat ^ oinv);
  assign pin_level  = (ext_drive & ext_val) | (~ext_drive & oen & drive_int) |
                      (~ext_drive & ~oen & pull);
  assign contention = ext_drive & oen;
  assign samp       = ien & pin_level;
  assign irq        = (hip & hie) | (lip & lie) | (rip & rie) | (fip & fie);

  function automatic logic [NPIN-1:0] clr(input logic [ADDR_W-1:0] a);
    return (bus_we && bus_addr == a) ? bus_wdata : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ien, oen, odat, oinv, pull, drv, afen, afsl} <= '0;
      {hie, lie, rie, fie} <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_IEN:  ien  <= bus_wdata;
        A_OEN:  oen  <= bus_wdata;
        A_ODAT: odat <= bus_wdata;
        A_OINV: oinv <= bus_wdata;
        A_PULL: pull <= bus_wdata;
        A_DRV:  drv  <= bus_wdata;
        A_AFEN: afen <= bus_wdata;
        A_AFSL: afsl <= bus_wdata;
        A_HIE:  hie  <= bus_wdata;
        A_LIE:  lie  <= bus_wdata;
        A_RIE:  rie  <= bus_wdata;
        A_FIE:  fie  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hip, lip, rip, fip, val_q} <= '0;
    end else begin
      val_q <= samp;
      hip   <= (hip & ~clr(A_HIP)) | samp;
      lip   <= (lip & ~clr(A_LIP)) | ~samp;
      rip   <= (rip & ~clr(A_RIP)) | (samp & ~val_q);
      fip   <= (fip & ~clr(A_FIP)) | (~samp & val_q);
    end
  end

  always_comb begin
    case (bus_addr)
      A_VAL:  bus_rdata = val_q;
      A_IEN:  bus_rdata = ien;
      A_OEN:  bus_rdata = oen;
      A_ODAT: bus_rdata = odat;
      A_OINV: bus_rdata = oinv;
      A_PULL: bus_rdata = pull;
      A_DRV:  bus_rdata = drv;
      A_AFEN: bus_rdata = afen;
      A_AFSL: bus_rdata = afsl;
      A_HIE:  bus_rdata = hie;
      A_HIP:  bus_rdata = hip;
      A_LIE:  bus_rdata = lie;
      A_LIP:  bus_rdata = lip;
      A_RIE:  bus_rdata = rie;
      A_RIP:  bus_rdata = rip;
      A_FIE:  bus_rdata = fie;
      A_FIP:  bus_rdata = fip;
      default: bus_rdata = '0;
    endcase
  end

  a_r2_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & ext_drive) == (ext_val & ext_drive));
  a_r4_high_tracks_value: assert property (@(posedge clk) disable iff (!rst_n)
    (hip & val_q) == val_q);
  a_r5_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((val_q & ~$past(val_q)) & ~rip) == '0);
  a_r6_rip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_RIP) |=> ((rip & $past(rip)) == $past(rip)));
  a_r6_lip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_LIP) |=> ((lip & $past(lip)) == $past(lip)));
  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (hie | lie | rie | fie) == '0 |-> irq == '0);
  a_r10_contention_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (contention & ~ext_drive) == '0);
endmodule

// File: tb/gpio_pin_irq_tb.sv
module gpio_pin_irq_tb;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [6:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, ext_drive = 0, ext_val = 0;
  logic [31:0] pin_level, contention, irq;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  gpio_pin_irq u_dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
                      .ext_drive, .ext_val, .pin_level, .contention, .irq);

  // nibbles: xdrv xval oen odat oinv pull ien | exp_level exp_value exp_contention
  localparam logic [39:0] VEC [6] = '{
    40'h00F500F550, 40'h00F5303620, 40'h000F0AFAA0,
    40'hC4FF00F77C, 40'hF9000F5910, 40'h324048FEE0};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    bus_we = 0; bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] rep(logic [3:0] n);
    return {8{n}};
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #25;
    // R8 reset state
    rd('h00, d); check("R8 value", d, 0);
    rd('h08, d); check("R8 oen", d, 0);
    rd('h38, d); check("R8 rise pending", d, 0);
    check("R8 irq", irq, 0);
    check("R8 level", pin_level, 0);
    @(negedge clk); rst_n = 1;

    foreach (VEC[i]) begin
      ext_drive = rep(VEC[i][39:36]); ext_val = rep(VEC[i][35:32]);
      wr('h08, rep(VEC[i][31:28])); wr('h0C, rep(VEC[i][27:24]));
      wr('h10, rep(VEC[i][23:20])); wr('h14, rep(VEC[i][19:16]));
      wr('h04, rep(VEC[i][15:12]));
      check("R1 R2 level", pin_level, rep(VEC[i][11:8]));
      check("R10 contention", contention, rep(VEC[i][3:0]));
      @(negedge clk);
      rd('h00, d); check("R3 value", d, rep(VEC[i][7:4]));
    end

    ext_drive = 0; ext_val = 0;
    wr('h04, '1); wr('h08, '1); wr('h0C, 0); wr('h10, 0); wr('h14, 0);
    @(negedge clk);
    wr('h28, '1); wr('h30, '1); wr('h38, '1); wr('h40, '1);
    @(negedge clk);
    rd('h38, d); check("R5 no rise while steady", d, 0);
    rd('h28, d); check("R4 high clear when low", d, 0);
    rd('h30, d); check("R6 low re-sets over clear", d, '1);

    wr('h0C, 32'h1); @(negedge clk);
    rd('h38, d); check("R5 rise pin0", d, 32'h1);
    rd('h28, d); check("R4 high pin0", d, 32'h1);
    wr('h38, 32'hFFFF_FFFE); @(negedge clk);
    rd('h38, d); check("R6 zero bits keep", d, 32'h1);
    wr('h34, 32'h1);
    check("R7 irq from rise", irq, 32'h1);
    wr('h38, 32'h1); @(negedge clk);
    rd('h38, d); check("R6 rise cleared", d, 0);
    check("R7 irq drops", irq, 0);
    wr('h34, 0); wr('h24, 32'h1);
    check("R7 irq from high", irq, 32'h1);
    wr('h28, 32'h1); @(negedge clk);
    rd('h28, d); check("R6 high set wins", d, 32'h1);
    wr('h24, 0);
    wr('h0C, 0); @(negedge clk);
    rd('h40, d); check("R5 fall pin0", d, 32'h1);

    wr('h00, '1); @(negedge clk);
    rd('h00, d); check("R3 value read-only", d, 0);
    wr('h44, '1);
    rd('h44, d); check("R9 unmapped reads zero", d, 0);
    rd('h08, d); check("R9 oen untouched", d, '1);
    rd('h0C, d); check("R9 odat untouched", d, 0);
    wr('h18, 32'hA5A5_A5A5);
    rd('h18, d); check("R9 drive strength stored", d, 32'hA5A5_A5A5);
    wr('h20, 32'h0F0F_1234);
    rd('h20, d); check("R9 alt select stored", d, 32'h0F0F_1234);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule